// File: doc/BRIEF.md
# Two-Stage Direct Digital Synthesis FM Generator

This block produces a frequency-modulated sine as a stream of offset-binary codes for an external DAC. It is built from two phase-accumulator stages, and each stage has its own clock and its own synchronous active-high reset. The modulating stage adds a modulation step to its phase once per modulating-clock cycle. It then reads a sine table at that phase.

The table sample is carried into the carrier clock domain as a whole word through a toggle handshake. There it is read as a signed value about mid-scale, multiplied by an unsigned deviation word and scaled down by the table data width. The result is added to a carrier step, which gives the instantaneous tuning word. The carrier stage accumulates that tuning word, and its registered phase addresses a second sine table. The output register of that table drives the DAC code.

Both tables are quarter-wave sine tables computed when the design is elaborated. The accumulator width and the table data width are parameters. The same RTL serves 12-bit and 8-bit builds.

Top module: `fmdds_fm_gen`

## Requirements
- R1: While `rst_car` is high at a carrier clock edge, the carrier accumulator, the carrier phase register, the tuning-word register and `dac_code` are cleared to zero. After release the carrier phase restarts from zero.
- R2: With `dev_word` zero, the output is a pure carrier regardless of the modulating stage. After the n-th carrier edge following reset release, `dac_code` equals the table code at phase (max(n-3,0)·`car_step`) mod 2^N, so the period is 2^N/`car_step` cycles.
- R3: The table code for phase p is 2^(D-1) + round(A·sin(2π(p+0.5)/2^N)), with A = 2^(D-1)-1 and rounding half away from zero. The code is offset binary, so it is never zero.
- R4: The tuning word is (`car_step` + floor(s·`dev_word`/2^D)) mod 2^N. Here s is the modulating-table code minus 2^(D-1), taken as a signed value, and `dev_word` is unsigned. A result at or above 2^N wraps.
- R5: A negative sample lowers the tuning word, and the scaled term rounds toward minus infinity. For example, s = -2047 and `dev_word` = 2048 give -1024.
- R6: The modulating phase register advances by `mod_step` on each `clk_mod` edge out of reset. Its value addresses the modulating table through one output register.
- R7: The carrier stage uses only complete modulating samples. A word captured in the carrier domain equals the held source word of the handshake.
- R8: A carrier reset does not discard the last delivered modulating sample. The tuning word is valid from the first carrier edge after release.
- R9: With N = 8 and D = 8, the block behaves as in R2 and R3 with a 256-entry phase space and 8-bit codes.
- R10: Out of reset, the carrier phase register advances each cycle by the tuning word registered two edges earlier.
- R11: A carrier step of 2^N/8 gives a period of exactly 8 output samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mod | input | 1 | Modulating-stage clock |
| rst_mod | input | 1 | Synchronous active-high reset, modulating domain |
| clk_car | input | 1 | Carrier-stage clock |
| rst_car | input | 1 | Synchronous active-high reset, carrier domain |
| mod_step | input | PHASE_W | Modulation phase step |
| car_step | input | PHASE_W | Centre carrier phase step |
| dev_word | input | PHASE_W | Deviation weight (unsigned) |
| dac_code | output | DATA_W | Offset-binary sample code for the DAC |

## Verification
The hard case is an exact, cycle-true check of the modulated output. The modulating sample reaches the carrier through a handshake whose latency depends on clock phase, so the bench freezes the modulator first. It resets the modulating stage with a step of a quarter or three quarters of the phase range, lets exactly one edge pass, and then sets the step to zero. The delivered sample then sits at the positive or negative peak. Next the bench resets only the carrier stage, which keeps that sample. From there the tuning word is a known constant, chosen so that the sum wraps or the scaled term rounds down, and every output code can be predicted from the table formula.

// File: rtl/fmdds_pkg.sv
package fmdds_pkg;

    localparam int unsigned DEF_PHASE_W = 12;
    localparam int unsigned DEF_DATA_W  = 12;
    localparam real         TWO_PI      = 6.283185307179586;

    // Mid-scale code of an offset-binary word of the given width.
    function automatic int unsigned mid_code(input int unsigned data_w);
        return 32'd1 << (data_w - 1);
    endfunction

    // First-quadrant magnitude for table index idx, sampled half a step
    // off the axis so the other quadrants follow by mirroring exactly.
    function automatic int quarter_sine(input int idx, input int phase_w,
                                        input int data_w);
        real amp;
        real ang;
        real val;
        amp = real'((1 << (data_w - 1)) - 1);
        ang = TWO_PI * (real'(idx) + 0.5) / real'(1 << phase_w);
        val = amp * $sin(ang);
        return int'($floor(val + 0.5));
    endfunction

endpackage

// File: rtl/fmdds_phase_acc.sv
module fmdds_phase_acc #(
    parameter int unsigned W = fmdds_pkg::DEF_PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] step,
    output logic [W-1:0] phase
);

    typedef struct packed {
        logic [W-1:0] sum;
        logic [W-1:0] addr;
    } acc_state_t;

    acc_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.sum  <= st.sum + step;
            st.addr <= st.sum;
        end
    end

    assign phase = st.addr;

endmodule

// File: rtl/fmdds_sine_rom.sv
module fmdds_sine_rom #(
    parameter int unsigned AW = fmdds_pkg::DEF_PHASE_W,
    parameter int unsigned DW = fmdds_pkg::DEF_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] code
);

    localparam int unsigned QW  = AW - 2;
    localparam int unsigned QN  = 1 << QW;
    localparam int unsigned MW  = DW - 1;
    localparam int unsigned MID = fmdds_pkg::mid_code(DW);

    logic [MW-1:0] qtab [QN];

    for (genvar gi = 0; gi < QN; gi++) begin : g_quarter
        assign qtab[gi] = MW'(fmdds_pkg::quarter_sine(gi, AW, DW));
    end

    logic [QW-1:0] qidx;
    logic [MW-1:0] mag;
    logic [DW-1:0] nxt;

    always_comb begin
        qidx = addr[QW-1:0];
        if (addr[AW-2]) begin
            qidx = ~qidx;
        end
        mag = qtab[qidx];
        if (addr[AW-1]) begin
            nxt = DW'(MID) - DW'(mag);
        end else begin
            nxt = DW'(MID) + DW'(mag);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else begin
            code <= nxt;
        end
    end

endmodule

// File: rtl/fmdds_word_xfer.sv
module fmdds_word_xfer #(
    parameter int unsigned W = fmdds_pkg::DEF_DATA_W
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_word,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_word,
    output logic [W-1:0] src_hold,
    output logic         dst_seen
);

    typedef struct packed {
        logic [W-1:0] hold;
        logic         req;
        logic         ack_s1;
        logic         ack_s2;
    } src_state_t;

    typedef struct packed {
        logic req_s1;
        logic req_s2;
        logic seen;
    } dst_state_t;

    src_state_t   s;
    dst_state_t   d;
    logic [W-1:0] word_q;

    // Source side: load a new word only after the previous one is acknowledged.
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            s <= '0;
        end else begin
            s.ack_s1 <= d.seen;
            s.ack_s2 <= s.ack_s1;
            if (s.ack_s2 == s.req) begin
                s.hold <= src_word;
                s.req  <= ~s.req;
            end
        end
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            d <= '0;
        end else begin
            d.req_s1 <= s.req;
            d.req_s2 <= d.req_s1;
            if (d.req_s2 != d.seen) begin
                d.seen <= d.req_s2;
            end
        end
    end

    // The delivered word survives a destination reset.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst && (d.req_s2 != d.seen)) begin
            word_q <= s.hold;
        end
    end

    assign dst_word = word_q;
    assign src_hold = s.hold;
    assign dst_seen = d.seen;

endmodule

// File: rtl/fmdds_tuning.sv
module fmdds_tuning #(
    parameter int unsigned N = fmdds_pkg::DEF_PHASE_W,
    parameter int unsigned D = fmdds_pkg::DEF_DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [D-1:0] mod_code,
    input  logic [N-1:0] centre,
    input  logic [N-1:0] weight,
    output logic [N-1:0] step_q
);

    localparam int unsigned PW = D + N + 1;

    logic signed [D-1:0]  smp;
    logic signed [N:0]    wgt;
    logic signed [PW-1:0] smp_x;
    logic signed [PW-1:0] wgt_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic        [N-1:0]  step_nxt;
    logic                 unused_hi;

    assign smp       = signed'({~mod_code[D-1], mod_code[D-2:0]});
    assign wgt       = signed'({1'b0, weight});
    assign smp_x     = PW'(smp);
    assign wgt_x     = PW'(wgt);
    assign prod      = smp_x * wgt_x;
    assign scaled    = prod >>> D;
    assign step_nxt  = centre + scaled[N-1:0];
    assign unused_hi = ^scaled[PW-1:N];

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else begin
            step_q <= step_nxt;
        end
    end

endmodule

// File: rtl/fmdds_fm_gen.sv
module fmdds_fm_gen #(
    parameter int unsigned PHASE_W = fmdds_pkg::DEF_PHASE_W,
    parameter int unsigned DATA_W  = fmdds_pkg::DEF_DATA_W
) (
    input  logic               clk_mod,
    input  logic               rst_mod,
    input  logic               clk_car,
    input  logic               rst_car,
    input  logic [PHASE_W-1:0] mod_step,
    input  logic [PHASE_W-1:0] car_step,
    input  logic [PHASE_W-1:0] dev_word,
    output logic [DATA_W-1:0]  dac_code
);

    logic [PHASE_W-1:0] mod_phase;
    logic [DATA_W-1:0]  mod_code;
    logic [DATA_W-1:0]  car_mod_code;
    logic [DATA_W-1:0]  xfer_hold;
    logic               xfer_seen;
    logic [PHASE_W-1:0] car_step_q;
    logic [PHASE_W-1:0] car_phase;

    fmdds_phase_acc #(.W(PHASE_W)) u_mod_acc (
        .clk   (clk_mod),
        .rst   (rst_mod),
        .step  (mod_step),
        .phase (mod_phase)
    );

    fmdds_sine_rom #(.AW(PHASE_W), .DW(DATA_W)) u_mod_rom (
        .clk  (clk_mod),
        .rst  (rst_mod),
        .addr (mod_phase),
        .code (mod_code)
    );

    fmdds_word_xfer #(.W(DATA_W)) u_xfer (
        .src_clk  (clk_mod),
        .src_rst  (rst_mod),
        .src_word (mod_code),
        .dst_clk  (clk_car),
        .dst_rst  (rst_car),
        .dst_word (car_mod_code),
        .src_hold (xfer_hold),
        .dst_seen (xfer_seen)
    );

    fmdds_tuning #(.N(PHASE_W), .D(DATA_W)) u_tune (
        .clk      (clk_car),
        .rst      (rst_car),
        .mod_code (car_mod_code),
        .centre   (car_step),
        .weight   (dev_word),
        .step_q   (car_step_q)
    );

    fmdds_phase_acc #(.W(PHASE_W)) u_car_acc (
        .clk   (clk_car),
        .rst   (rst_car),
        .step  (car_step_q),
        .phase (car_phase)
    );

    fmdds_sine_rom #(.AW(PHASE_W), .DW(DATA_W)) u_car_rom (
        .clk  (clk_car),
        .rst  (rst_car),
        .addr (car_phase),
        .code (dac_code)
    );

endmodule

// File: rtl/fmdds_fm_gen_chk.sv
module fmdds_fm_gen_chk #(
    parameter int unsigned N = fmdds_pkg::DEF_PHASE_W,
    parameter int unsigned D = fmdds_pkg::DEF_DATA_W
) (
    input logic         clk_mod,
    input logic         rst_mod,
    input logic         clk_car,
    input logic         rst_car,
    input logic [N-1:0] mod_step,
    input logic [N-1:0] mod_phase,
    input logic [N-1:0] car_step_q,
    input logic [N-1:0] car_phase,
    input logic [D-1:0] dac_code,
    input logic [D-1:0] xfer_hold,
    input logic         xfer_seen,
    input logic [D-1:0] car_mod_code
);

    a_r1_phase_restart: assert property (@(posedge clk_car) disable iff (rst_car)
        $past(rst_car) |-> (car_phase == '0));

    a_r3_code_nonzero: assert property (@(posedge clk_car) disable iff (rst_car)
        !$past(rst_car) |-> (dac_code != '0));

    a_r6_mod_phase_step: assert property (@(posedge clk_mod) disable iff (rst_mod)
        (!$past(rst_mod) && !$past(rst_mod, 2))
        |-> (mod_phase == $past(mod_phase) + $past(mod_step, 2)));

    a_r10_car_phase_step: assert property (@(posedge clk_car) disable iff (rst_car)
        (!$past(rst_car) && !$past(rst_car, 2))
        |-> (car_phase == $past(car_phase) + $past(car_step_q, 2)));

    a_r7_whole_word: assert property (@(posedge clk_car) disable iff (rst_car || rst_mod)
        (!$past(rst_car) && !$past(rst_mod) && (xfer_seen != $past(xfer_seen)))
        |-> (car_mod_code == $past(xfer_hold)));

endmodule

bind fmdds_fm_gen fmdds_fm_gen_chk #(.N(PHASE_W), .D(DATA_W)) u_chk (
    .clk_mod      (clk_mod),
    .rst_mod      (rst_mod),
    .clk_car      (clk_car),
    .rst_car      (rst_car),
    .mod_step     (mod_step),
    .mod_phase    (mod_phase),
    .car_step_q   (car_step_q),
    .car_phase    (car_phase),
    .dac_code     (dac_code),
    .xfer_hold    (xfer_hold),
    .xfer_seen    (xfer_seen),
    .car_mod_code (car_mod_code)
);

// File: tb/fmdds_fm_gen_bench.sv
module fmdds_fm_gen_bench;

    logic        clk_m = 1'b0;
    logic        clk_c = 1'b0;
    logic        rst_m = 1'b1;
    logic        rst_c = 1'b1;
    logic [11:0] kh = 12'd37;
    logic [11:0] kc = 12'd64;
    logic [11:0] kx = 12'd0;
    logic [7:0]  kh8 = 8'd5;
    logic [7:0]  kc8 = 8'd16;
    logic [7:0]  kx8 = 8'd0;
    logic [11:0] dac;
    logic [7:0]  dac8;

    int    n_chk = 0;
    int    n_err = 0;
    int    q12[$];
    int    q8[$];
    bit    mon_en = 1'b0;
    string cur_req = "R2";
    int    cyc = 0;

    always #7 clk_m = ~clk_m;
    always #5 clk_c = ~clk_c;

    fmdds_fm_gen u_fmdds_fm_gen (
        .clk_mod (clk_m), .rst_mod (rst_m), .clk_car (clk_c), .rst_car (rst_c),
        .mod_step (kh), .car_step (kc), .dev_word (kx), .dac_code (dac)
    );

    fmdds_fm_gen #(.PHASE_W(8), .DATA_W(8)) u_fmdds_fm_gen_w8 (
        .clk_mod (clk_m), .rst_mod (rst_m), .clk_car (clk_c), .rst_car (rst_c),
        .mod_step (kh8), .car_step (kc8), .dev_word (kx8), .dac_code (dac8)
    );

    // Table code from the requirement formula.
    function automatic int ref_code(input int p, input int nb, input int db);
        real amp;
        real x;
        real r;
        amp = real'((1 << (db - 1)) - 1);
        x   = amp * $sin(6.283185307179586 * (real'(p) + 0.5) / real'(1 << nb));
        if (x >= 0.0) r = $floor(x + 0.5);
        else          r = -$floor(-x + 0.5);
        return (1 << (db - 1)) + int'(r);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops expected codes and compares after each carrier edge.
    always @(negedge clk_c) begin
        if (mon_en) begin
            if (q12.size() > 0) begin
                int e;
                e = q12.pop_front();
                check(cur_req, int'(dac), e);
            end
            if (q8.size() > 0) begin
                int e;
                e = q8.pop_front();
                check("R9", int'(dac8), e);
            end
        end
    end

    // Driver: reset the carrier, push the expected stream, release.
    task automatic carrier_run(input string req, input int c_step, input int c_dev,
                               input int k12, input int k8, input int cnt);
        @(negedge clk_c);
        rst_c = 1'b1;
        kc    = 12'(c_step);
        kx    = 12'(c_dev);
        repeat (2) @(negedge clk_c);
        check("R1", int'(dac), 0);
        check("R1", int'(dac8), 0);
        cur_req = req;
        for (int n = 1; n <= cnt; n++) begin
            int s;
            s = (n >= 3) ? (n - 3) : 0;
            q12.push_back(ref_code((s * k12) % 4096, 12, 12));
            q8.push_back(ref_code((s * k8) % 256, 8, 8));
        end
        rst_c = 1'b0;
        @(posedge clk_c);
        mon_en = 1'b1;
        wait (q12.size() == 0 && q8.size() == 0);
        mon_en = 1'b0;
    endtask

    // R6: one modulating edge with step ph, then step zero freezes the phase.
    task automatic freeze_mod(input int ph);
        @(negedge clk_m);
        rst_m = 1'b1;
        kh    = 12'(ph);
        repeat (3) @(negedge clk_m);
        rst_m = 1'b0;
        @(negedge clk_m);
        kh = 12'd0;
        repeat (40) @(negedge clk_m);
    endtask

    initial begin
        repeat (4) @(negedge clk_c);
        rst_m = 1'b0;
        repeat (10) @(negedge clk_c);
        // R2 R3 R10: pure carrier, modulator running, period 64
        carrier_run("R2 R3 R10", 64, 0, 64, 16, 200);
        // R11: step of one eighth of the phase space
        carrier_run("R11", 512, 0, 512, 16, 48);
        // R4 R7 R8: positive peak, 3137 + 1023 wraps to 64
        freeze_mod(1024);
        carrier_run("R4 R7 R8", 3137, 2048, 64, 16, 140);
        // R5 R6: negative peak, floor gives -1024, 1152 - 1024 = 128
        freeze_mod(3072);
        carrier_run("R5 R6", 1152, 2048, 128, 16, 100);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk_c);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                $finish;
            end
        end
    end

endmodule